// File: doc/BRIEF.md
# Five-Function ALU with Zero Flag

This block is the arithmetic core of a simple integer datapath. It takes two 32-bit operands and a 4-bit operation select. It returns a 32-bit result together with a flag that reports an all-zero result. Five operations are supported: bitwise AND, bitwise OR, addition, subtraction and signed set-less-than. Address calculation uses addition. An equality branch subtracts the two operands and tests the zero flag.

The block is purely combinational. It has no clock, no reset and no stored state, so the outputs follow the inputs within the same cycle. Addition, subtraction and set-less-than share one adder. The adder runs in subtract mode for both subtraction and the compare. The select encoding is sparse and fixed. Every code that is not listed gives a result of zero, so a bad decode can never leak stale or partial data.

Top module: `alu_core`

## Requirements
- R1: Select code 4'b0000 drives the result with the bitwise AND of operand A and operand B.
- R2: Select code 4'b0001 drives the result with the bitwise OR of the two operands.
- R3: Select code 4'b0010 drives the result with A plus B, wrapping modulo 2^32 with no carry out.
- R4: Select code 4'b0110 drives the result with A minus B, wrapping modulo 2^32.
- R5: Select code 4'b0111 compares A and B as two's-complement signed values. The result is 1 in bit 0 when A < B and 0 otherwise, and bits 31:1 are always zero.
- R6: The zero flag is high exactly when all 32 result bits are zero, for every select code.
- R7: Every select code other than the five above gives a result of zero, and therefore a high zero flag.
- R8: The outputs are a pure function of the present inputs: a change on any input is visible at the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand (A) |
| b_i | input | 32 | Second operand (B) |
| op_i | input | 4 | Operation select code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The hardest cases are the signed compares where the sign bits of the operands differ. In those cases the raw difference overflows and its sign bit gives the wrong answer. Uniform random operands seldom land near these limits. The stimulus therefore pairs the most negative and most positive values, minus one against zero, and random operands whose top bit is forced to opposite values. Equal operands under subtraction are also driven on purpose, because random values almost never make the zero flag rise.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111
    } alu_op_e;

    function automatic logic op_is_known(input logic [SEL_W-1:0] code);
        return (code == OP_AND) || (code == OP_OR) || (code == OP_ADD)
            || (code == OP_SUB) || (code == OP_SLT);
    endfunction
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o
);
    always_comb begin
        and_o = opa_i & opb_i;
        or_o  = opa_i | opb_i;
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         sub_mode_i,
    output logic [W-1:0] sum_o,
    output logic         less_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] opb_eff;
    logic         sign_differs;

    always_comb begin
        opb_eff      = sub_mode_i ? ~opb_i : opb_i;
        sum_o        = opa_i + opb_eff + {{(W-1){1'b0}}, sub_mode_i};
        sign_differs = opa_i[MSB] ^ opb_i[MSB];
        // when signs differ the negative operand is the smaller one
        less_o       = sign_differs ? opa_i[MSB] : sum_o[MSB];
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int W     = 32,
    parameter int GRP_W = 8
) (
    input  logic [W-1:0] value_i,
    output logic         zero_o
);
    localparam int GROUPS = (W + GRP_W - 1) / GRP_W;
    localparam int PAD_W  = GROUPS * GRP_W;

    logic [PAD_W-1:0]  padded;
    logic [GROUPS-1:0] grp_any;

    always_comb begin
        padded = '0;
        padded[W-1:0] = value_i;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_any[g] = |padded[g*GRP_W +: GRP_W];
    end

    assign zero_o = ~|grp_any;
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [SEL_W-1:0]  op_i,
    output logic [DATA_W-1:0] result_o,
    output logic              zero_o
);
    logic [DATA_W-1:0] and_res;
    logic [DATA_W-1:0] or_res;
    logic [DATA_W-1:0] sum_res;
    logic              less_res;
    logic              sub_mode;

    assign sub_mode = (op_i == OP_SUB) || (op_i == OP_SLT);

    alu_logic_unit #(.W(DATA_W)) u_logic (
        .opa_i (a_i),
        .opb_i (b_i),
        .and_o (and_res),
        .or_o  (or_res)
    );

    alu_arith_unit #(.W(DATA_W)) u_arith (
        .opa_i      (a_i),
        .opb_i      (b_i),
        .sub_mode_i (sub_mode),
        .sum_o      (sum_res),
        .less_o     (less_res)
    );

    always_comb begin
        unique case (op_i)
            OP_AND:  result_o = and_res;
            OP_OR:   result_o = or_res;
            OP_ADD,
            OP_SUB:  result_o = sum_res;
            OP_SLT:  result_o = {{(DATA_W-1){1'b0}}, less_res};
            default: result_o = '0;
        endcase
    end

    alu_zero_detect #(.W(DATA_W), .GRP_W(8)) u_zero (
        .value_i (result_o),
        .zero_o  (zero_o)
    );

    always_comb begin
        // R7
        unlisted_op_chk: assert (op_is_known(op_i) || (result_o == '0 && zero_o));
        // R5
        slt_upper_chk: assert (op_i != OP_SLT || result_o[DATA_W-1:1] == '0);
        // R4
        equal_sub_zero_chk: assert (!(op_i == OP_SUB && a_i == b_i) || zero_o);
        // R3
        add_inverse_chk: assert (op_i != OP_ADD || (result_o - b_i) == a_i);
        // R6
        zero_flag_chk: assert (zero_o == ($countones(result_o) == 0));
    end
endmodule

// File: tb/alu_core_test.sv
module alu_core_test;
    import alu_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] a, b;
    logic [3:0]  op;
    logic [31:0] res;
    logic        zf;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    alu_core uut (
        .a_i      (a),
        .b_i      (b),
        .op_i     (op),
        .result_o (res),
        .zero_o   (zf)
    );

    function automatic logic [31:0] model(input logic [3:0] c,
                                          input logic [31:0] x,
                                          input logic [31:0] y);
        case (c)
            4'b0000: return x & y;
            4'b0001: return x | y;
            4'b0010: return x + y;
            4'b0110: return x - y;
            4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] exp_r;
        @(negedge clk);
        op = c; a = x; b = y;
        #1;
        exp_r = model(c, x, y);
        checks++;
        if (res !== exp_r) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h result=%h expected=%h", tag(c), c, x, y, res, exp_r);
        end
        checks++;
        if (zf !== (exp_r == 32'd0)) begin
            errors++;
            $display("FAIL R6 op=%b a=%h b=%h zero=%b expected=%b", c, x, y, zf, (exp_r == 32'd0));
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] codes [5];
        int unsigned seed;
        codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0010;
        codes[3] = 4'b0110; codes[4] = 4'b0111;
        seed = $urandom(32'd20240611);
        op = 4'b0000; a = '0; b = '0;
        #1;
        // initial state: AND of zeros gives zero result and flag (R1, R6)
        checks++;
        if (res !== 32'd0 || zf !== 1'b1) begin
            errors++;
            $display("FAIL R1 initial result=%h zero=%b expected=00000000 1", res, zf);
        end

        // directed corners
        apply(4'b0000, 32'hF0F0_1234, 32'h0FF0_FFFF);          // R1
        apply(4'b0001, 32'hF000_0000, 32'h0000_000F);          // R2
        apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);          // R3 wrap to zero
        apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);          // R3 signed overflow
        apply(4'b0110, 32'h1234_5678, 32'h1234_5678);          // R4 equal, zero flag
        apply(4'b0110, 32'h0000_0000, 32'h0000_0001);          // R4 borrow
        apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);          // R5 min < max
        apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);          // R5 max > min
        apply(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);          // R5 -1 < 0
        apply(4'b0111, 32'h0000_0000, 32'hFFFF_FFFF);          // R5 0 > -1
        apply(4'b0111, 32'h8000_0000, 32'h8000_0000);          // R5 equal
        apply(4'b0111, 32'h0000_0005, 32'h0000_0009);          // R5 small positives

        // every select code including unlisted ones (R7)
        for (int c = 0; c < 16; c++) begin
            apply(c[3:0], 32'hDEAD_BEEF, 32'h1357_9BDF);
        end

        // random operands on each listed code
        for (int i = 0; i < 400; i++) begin
            logic [31:0] x, y;
            x = $urandom; y = $urandom;
            if (i % 4 == 1) y = x;
            if (i % 4 == 2) begin x[31] = 1'b1; y[31] = 1'b0; end
            if (i % 4 == 3) begin x[31] = 1'b0; y[31] = 1'b1; end
            apply(codes[i % 5], x, y);
        end

        // R8: input change with no clock edge in between
        @(negedge clk);
        op = 4'b0010; a = 32'd3; b = 32'd4;
        #0.5;
        a = 32'd10;
        #0.5;
        checks++;
        if (res !== 32'd14) begin
            errors++;
            $display("FAIL R8 result=%h expected=0000000e", res);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule